// File: doc/BRIEF.md
# Fixed-Point Fractional Gain Scaler

This block scales an unsigned integer sample by an unsigned gain known to be below one and returns an integer rounded to nearest. The sample carries only integer bits, with no fractional bits stored. The gain carries only fraction bits, because its integer part is always zero. An ordinary unsigned multiplier of SAMPLE_W by GAIN_W bits therefore yields a mixed-format product with SAMPLE_W integer bits and GAIN_W fraction bits. The binary point is implied and never computed.

The product is rounded back to an integer by adding one half, which is a single 1 in the top fraction bit, and then dropping every fraction bit. Because the gain is below one, the rounded value always fits in SAMPLE_W bits, so no saturation is needed. A parameter can select plain truncation instead of rounding. A second parameter picks the multiplier structure: either the native operator or an explicit shift-and-add array.

Operands are captured on a rising clock edge when the valid input is high. The rounded result, the full product and a valid flag come out of registers one cycle later.

Top module: `fxs_gain_scaler`

## Requirements
- R1: `out_product` equals `in_sample * in_gain` at full width SAMPLE_W+GAIN_W. Its binary point lies GAIN_W bits from the right.
- R2: With rounding selected (the default), `out_result` equals floor((product + 2^(GAIN_W-1)) / 2^GAIN_W). A product whose fraction is exactly one half rounds up, so sample 1 with gain 8/16 gives 1.
- R3: Sample 15 with gain 15/16 gives a product of 0xE1 (14.0625) and a rounded result of 14.
- R4: Operands presented with `in_valid` high on a rising edge produce `out_valid` high, with the matching result and product, on the next cycle. Back-to-back operands stream at one per cycle.
- R5: A synchronous active-high `rst` forces `out_valid`, `out_result` and `out_product` to zero on the next edge, and it overrides `in_valid`.
- R6: In a cycle where `in_valid` is low, `out_valid` falls and `out_result` and `out_product` keep their previous values, whatever the operand inputs carry.
- R7: A gain of zero gives a result and product of zero for any sample. A sample of zero gives zero for any gain.
- R8: The rounded result never exceeds the sample, and the rounding add never carries beyond SAMPLE_W integer bits.
- R9: With truncation selected, `out_result` equals the product shifted right by GAIN_W, discarding the fraction.
- R10: The shift-and-add multiplier variant produces the same product and result as the native variant for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be captured |
| in_sample | input | SAMPLE_W | Unsigned integer sample, no fraction bits |
| in_gain | input | GAIN_W | Unsigned gain fraction, value in_gain / 2^GAIN_W |
| out_valid | output | 1 | Result registers hold a fresh value |
| out_result | output | SAMPLE_W | Integer result, rounded or truncated |
| out_product | output | SAMPLE_W+GAIN_W | Full-precision product, GAIN_W fraction bits |

## Verification
Every result of this block is due exactly one rising edge after its operands are presented: the valid flag, the rounded result and the full product all come from the same single register stage. The bench changes operands on the falling edge and reads the outputs on the following falling edge, so exactly one capture edge lies between stimulus and check. The exhaustive sweep streams a new pair on every cycle and compares each output against the pair driven one cycle before. The hold and reset checks read the registers on the first falling edge after the cycle in which valid was low or reset was high.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

   typedef enum logic [0:0] {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } round_mode_e;

   typedef enum logic [0:0] {
      MUL_NATIVE    = 1'b0,
      MUL_SHIFT_ADD = 1'b1
   } mult_impl_e;

endpackage

// File: rtl/fxs_mult.sv
module fxs_mult
   import fxs_pkg::*;
#(
   parameter int         SAMPLE_W = 4,
   parameter int         GAIN_W   = 4,
   parameter mult_impl_e IMPL     = MUL_NATIVE,
   localparam int        PROD_W   = SAMPLE_W + GAIN_W
) (
   input  logic [SAMPLE_W-1:0] a_i,
   input  logic [GAIN_W-1:0]   b_i,
   output logic [PROD_W-1:0]   p_o
);

   if (SAMPLE_W < 1 || GAIN_W < 1) begin : g_bad_width
      $error("fxs_mult: operand widths must be at least one bit");
   end

   if (IMPL == MUL_NATIVE) begin : g_native
      always_comb begin
         p_o = PROD_W'(a_i) * PROD_W'(b_i);
      end
   end else begin : g_shift_add
      logic [PROD_W-1:0] pp [GAIN_W];

      for (genvar i = 0; i < GAIN_W; i++) begin : g_pp
         always_comb begin
            pp[i] = b_i[i] ? (PROD_W'(a_i) << i) : '0;
         end
      end

      always_comb begin
         logic [PROD_W-1:0] acc;
         acc = '0;
         for (int k = 0; k < GAIN_W; k++) begin
            acc = acc + pp[k];
         end
         p_o = acc;
      end
   end

endmodule

// File: rtl/fxs_round.sv
module fxs_round
   import fxs_pkg::*;
#(
   parameter int          SAMPLE_W = 4,
   parameter int          GAIN_W   = 4,
   parameter round_mode_e MODE     = RND_HALF_UP,
   localparam int         PROD_W   = SAMPLE_W + GAIN_W
) (
   input  logic [PROD_W-1:0]   p_i,
   output logic [SAMPLE_W-1:0] r_o
);

   if (MODE == RND_HALF_UP) begin : g_half_up
      localparam logic [PROD_W:0] HALF = (PROD_W+1)'(1) << (GAIN_W - 1);
      logic [PROD_W:0] biased;

      always_comb begin
         biased = {1'b0, p_i} + HALF;
         r_o    = biased[PROD_W-1:GAIN_W];
      end

      // R8
      always_comb begin
         if (!$isunknown(biased)) begin
            round_carry_chk: assert (biased[PROD_W] == 1'b0)
               else $error("rounding add carried past the integer field");
         end
      end
   end else begin : g_trunc
      always_comb begin
         r_o = p_i[PROD_W-1:GAIN_W];
      end
   end

endmodule

// File: rtl/fxs_gain_scaler.sv
module fxs_gain_scaler
   import fxs_pkg::*;
#(
   parameter int          SAMPLE_W   = 4,
   parameter int          GAIN_W     = 4,
   parameter round_mode_e ROUND_MODE = RND_HALF_UP,
   parameter mult_impl_e  MULT_IMPL  = MUL_NATIVE,
   localparam int         PROD_W     = SAMPLE_W + GAIN_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic [GAIN_W-1:0]   in_gain,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_result,
   output logic [PROD_W-1:0]   out_product
);

   if (SAMPLE_W < 1 || GAIN_W < 1) begin : g_bad_width
      $error("fxs_gain_scaler: SAMPLE_W and GAIN_W must be positive");
   end

   logic [PROD_W-1:0]   prod_c;
   logic [SAMPLE_W-1:0] res_c;

   fxs_mult #(
      .SAMPLE_W (SAMPLE_W),
      .GAIN_W   (GAIN_W),
      .IMPL     (MULT_IMPL)
   ) u_mult (
      .a_i (in_sample),
      .b_i (in_gain),
      .p_o (prod_c)
   );

   fxs_round #(
      .SAMPLE_W (SAMPLE_W),
      .GAIN_W   (GAIN_W),
      .MODE     (ROUND_MODE)
   ) u_round (
      .p_i (prod_c),
      .r_o (res_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_product <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= res_c;
            out_product <= prod_c;
         end
      end
   end

   // R4
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_product)));

   // R7
   zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_gain == '0) |=> (out_result == '0 && out_product == '0));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_result <= $past(in_sample)));

   // R5
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && out_result == '0 && out_product == '0));

endmodule

// File: tb/tb_fxs_gain_scaler.sv
`timescale 1ns/1ps
module tb_fxs_gain_scaler;
   import fxs_pkg::*;

   localparam int SW = 4;
   localparam int GW = 4;
   localparam int PW = SW + GW;
   localparam int NV = 10;

   // packed as {sample, gain, product, rounded result}
   localparam logic [19:0] VEC [NV] = '{
      {4'd15, 4'd15, 8'hE1, 4'd14},
      {4'd1,  4'd8,  8'd8,  4'd1 },
      {4'd1,  4'd7,  8'd7,  4'd0 },
      {4'd0,  4'd9,  8'd0,  4'd0 },
      {4'd9,  4'd0,  8'd0,  4'd0 },
      {4'd15, 4'd1,  8'd15, 4'd1 },
      {4'd7,  4'd8,  8'd56, 4'd4 },
      {4'd5,  4'd9,  8'd45, 4'd3 },
      {4'd12, 4'd3,  8'd36, 4'd2 },
      {4'd10, 4'd12, 8'd120,4'd8 }
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [SW-1:0] in_sample = '0;
   logic [GW-1:0] in_gain = '0;

   logic          ov_a, ov_t, ov_s;
   logic [SW-1:0] r_a, r_t, r_s;
   logic [PW-1:0] p_a, p_t, p_s;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fxs_gain_scaler #(.SAMPLE_W(SW), .GAIN_W(GW)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .in_gain(in_gain), .out_valid(ov_a), .out_result(r_a), .out_product(p_a));

   fxs_gain_scaler #(.SAMPLE_W(SW), .GAIN_W(GW), .ROUND_MODE(RND_TRUNC)) dut_trunc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .in_gain(in_gain), .out_valid(ov_t), .out_result(r_t), .out_product(p_t));

   fxs_gain_scaler #(.SAMPLE_W(SW), .GAIN_W(GW), .MULT_IMPL(MUL_SHIFT_ADD)) dut_sa (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .in_gain(in_gain), .out_valid(ov_s), .out_result(r_s), .out_product(p_s));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] ref_round(input int s, input int g);
      return SW'((s * g + (1 << (GW - 1))) >> GW);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic check_all(input int s, input int g, input string tag);
      check({tag, " R4 valid"}, 32'(ov_a), 32'd1);
      check({tag, " R1 product"}, 32'(p_a), 32'(s * g));
      check({tag, " R2 rounded"}, 32'(r_a), 32'(ref_round(s, g)));
      check({tag, " R9 truncated"}, 32'(r_t), 32'((s * g) >> GW));
      check({tag, " R10 shift-add product"}, 32'(p_s), 32'(s * g));
      check({tag, " R10 shift-add result"}, 32'(r_s), 32'(ref_round(s, g)));
      check({tag, " R8 bound"}, 32'(r_a <= SW'(s)), 32'd1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [SW-1:0] hs;
      logic [PW-1:0] hp;
      repeat (3) @(negedge clk);
      // R5: reset state
      check("R5 reset valid", 32'(ov_a), 32'd0);
      check("R5 reset result", 32'(r_a), 32'd0);
      check("R5 reset product", 32'(p_a), 32'd0);
      rst = 1'b0;
      @(negedge clk);

      // table of directed vectors, one per capture
      for (int i = 0; i < NV; i++) begin
         in_sample = VEC[i][19:16];
         in_gain   = VEC[i][15:12];
         in_valid  = 1'b1;
         @(negedge clk);
         check($sformatf("R1 table %0d product", i), 32'(p_a), 32'(VEC[i][11:4]));
         check($sformatf("R2 table %0d result", i), 32'(r_a), 32'(VEC[i][3:0]));
         if (i == 0) begin
            check("R3 0xE1 product", 32'(p_a), 32'hE1);
            check("R3 rounded 14", 32'(r_a), 32'd14);
         end
         if (i == 1) check("R2 half rounds up", 32'(r_a), 32'd1);
         if (i == 3 || i == 4) check("R7 zero operand", 32'(r_a), 32'd0);
      end

      // R6: idle cycle holds data while operands change
      hs = r_a; hp = p_a;
      in_valid  = 1'b0;
      in_sample = 4'd15;
      in_gain   = 4'd15;
      @(negedge clk);
      check("R6 valid low", 32'(ov_a), 32'd0);
      check("R6 result held", 32'(r_a), 32'(hs));
      check("R6 product held", 32'(p_a), 32'(hp));

      // R4/R10/R9: exhaustive back-to-back sweep, checked one cycle later
      for (int s = 0; s < (1 << SW); s++) begin
         for (int g = 0; g < (1 << GW); g++) begin
            in_sample = SW'(s);
            in_gain   = GW'(g);
            in_valid  = 1'b1;
            @(negedge clk);
            check_all(s, g, "sweep");
            if (g == 0 || s == 0) check("R7 zero sweep", 32'(r_a), 32'd0);
         end
      end

      // R5: reset overrides a valid capture
      in_sample = 4'd11; in_gain = 4'd13; in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R5 reset over valid", 32'(ov_a), 32'd0);
      check("R5 reset clears result", 32'(r_a), 32'd0);
      check("R5 reset clears product", 32'(p_a), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R4 after reset", 32'(ov_a), 32'd1);
      check("R2 after reset", 32'(r_a), 32'(ref_round(11, 13)));
      in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule